// File: doc/BRIEF.md
# Hardware store busy controller

This block is the synchronous controller for the store handshake of a battery-free nonvolatile SRAM. Several such devices can share one open-drain, active-low store/busy line. The line can be pulled low from outside to request a copy of the SRAM contents into the nonvolatile array. The device then pulls the same line low for as long as it is busy. The controller keeps a dirty latch that any completed host write sets. A request only turns into a store when that latch is set. A device with nothing new to save leaves the line alone, so ganged devices cannot keep re-triggering each other.

After reset, the controller holds the line low and blocks host access until power is good. It then runs a power-up recall of fixed length. In normal operation it synchronises the line and filters it for a minimum low width. Once a request is taken, it blocks new host accesses at once. Only the write already in flight in that cycle is allowed to finish. After a short fixed delay it starts the store engine and drives the line low. It releases the line when the engine reports done, or when the nominal store time runs out. A loss of power good while idle is handled as a store request under the same dirty rule. All durations are clock counts set by parameters.

Top module: `nv_store_handshake`

## Requirements
- R1: While reset is released but `powerGood` is still low, `pullDown` and `accInhibit` are high and neither `storeStart` nor `recallStart` pulses.
- R2: When `powerGood` rises after reset, `recallStart` pulses for exactly one cycle. `pullDown` and `accInhibit` then stay high for exactly RECALL_CLKS cycles and are released together. The dirty latch is cleared at that point.
- R3: A host write completes in a cycle with `accReq`=1, `accWrite`=1 and `accInhibit`=0. A completed write sets the dirty latch, and the latch stays set until a store or recall finishes.
- R4: `lineIn` (1 = released, 0 = pulled low) passes through a two-flop synchroniser. It counts as a request only after MIN_LOW consecutive low samples. A shorter low pulse has no effect.
- R5: A request taken with the dirty latch set raises `accInhibit` in the next cycle. After DELAY_CLKS more cycles, `storeStart` pulses once and `pullDown` rises. From the first low `lineIn` cycle, `pullDown` rises 2+MIN_LOW+DELAY_CLKS clock edges later.
- R6: A request taken with the dirty latch clear starts no store, never drives `pullDown` and never raises `accInhibit`. Each low pulse on the line is taken as at most one request.
- R7: A write that completes in the same cycle the request is taken counts as dirty, so that request starts a store.
- R8: No host write is accepted from the cycle after the request is taken until the store ends. `accInhibit` is high for exactly DELAY_CLKS+STORE_CLKS cycles per timed store.
- R9: A store ends on an `engineDone` pulse, or after STORE_CLKS cycles if no pulse arrives. `pullDown` and `accInhibit` fall in the cycle after the end, and the dirty latch is cleared.
- R10: The device's own low drive on the line, including the synchroniser lag after release, never counts as a new request.
- R11: With the controller idle, a low `powerGood` acts as a store request under the same dirty rule. While it stays low with the latch clear, nothing is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Sampled level of the shared store/busy line, 0 = low |
| accReq | input | 1 | Host SRAM access in this cycle |
| accWrite | input | 1 | The access is a write |
| powerGood | input | 1 | Supply is good; low while idle requests a store |
| engineDone | input | 1 | One-cycle pulse: the store engine has finished |
| pullDown | output | 1 | Enable of the open-drain pull-down on the line |
| storeStart | output | 1 | One-cycle pulse starting the store engine |
| recallStart | output | 1 | One-cycle pulse starting the power-up recall |
| accInhibit | output | 1 | Host reads and writes are blocked |

## Verification
The sharpest collision is between a host write completing and a line request being taken in the same clock. The write must still count as dirty and still start a store. The bench places a write exactly in the cycle after the request filter fills, on a device that is clean. It judges the case by whether a store follows, with the usual latency and length. A second collision is the release of the device's own drive, followed at once by a new write while the synchroniser still shows the line low. That case passes when the line stays undriven and the fresh write is later consumed by a real request.

// File: rtl/nvsh_pkg.sv
package nvsh_pkg;

  typedef enum logic [2:0] {
    ST_WAITPG,
    ST_RECALL,
    ST_IDLE,
    ST_DRAIN,
    ST_STORE
  } stateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;    // restart the shared phase counter
    logic clrDirty;  // a store or recall has finished
    logic takeReq;   // the pending line request is consumed
  } ctlStrobeT;

endpackage

// File: rtl/nvsh_datapath.sv
module nvsh_datapath
  import nvsh_pkg::*;
#(
  parameter int MIN_LOW = 4,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  logic             accReq,
  input  logic             accWrite,
  input  logic             accInhibit,
  input  logic             pullDown,
  input  ctlStrobeT        strobe,
  output logic             extReq,
  output logic             dirtyNow,
  output logic [CNT_W-1:0] cnt
);

  localparam int LOW_W = (MIN_LOW > 1) ? $clog2(MIN_LOW) : 1;
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(MIN_LOW - 1);

  logic [1:0]       syncQ;
  logic             lineS;
  logic             armed;
  logic [LOW_W-1:0] lowCnt;
  logic             dirty;
  logic             wrDone;

  // Two-flop synchroniser, idles at the released level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], lineIn};
  end
  assign lineS = syncQ[1];

  // Armed only after the line is seen released while not self-driving
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          armed <= 1'b0;
    else if (pullDown || strobe.takeReq) armed <= 1'b0;
    else if (lineS)                     armed <= 1'b1;
  end

  // Minimum low width filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  lowCnt <= '0;
    else if (lineS || !armed)   lowCnt <= '0;
    else if (lowCnt != LOW_LAST) lowCnt <= lowCnt + 1'b1;
  end
  assign extReq = armed && !lineS && (lowCnt == LOW_LAST);

  // Dirty latch
  assign wrDone = accReq && accWrite && !accInhibit;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dirty <= 1'b0;
    else if (strobe.clrDirty) dirty <= 1'b0;
    else if (wrDone)          dirty <= 1'b1;
  end
  assign dirtyNow = dirty || wrDone;

  // Shared saturating phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.clrCnt) cnt <= '0;
    else if (cnt != '1)     cnt <= cnt + 1'b1;
  end

  // R3
  write_sets_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrDone && !strobe.clrDirty) |=> dirty);

  // R8
  inhibit_blocks_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accInhibit && !strobe.clrDirty) |=> $stable(dirty));

  // R10
  own_drive_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    pullDown |=> !extReq);

endmodule

// File: rtl/nvsh_control.sv
module nvsh_control
  import nvsh_pkg::*;
#(
  parameter int DELAY_CLKS  = 3,
  parameter int STORE_CLKS  = 800000,
  parameter int RECALL_CLKS = 20000,
  parameter int CNT_W       = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             powerGood,
  input  logic             engineDone,
  input  logic             extReq,
  input  logic             dirtyNow,
  input  logic [CNT_W-1:0] cnt,
  output ctlStrobeT        strobe,
  output logic             pullDown,
  output logic             accInhibit,
  output logic             storeStart,
  output logic             recallStart
);

  localparam logic [CNT_W-1:0] DELAY_LAST  = CNT_W'(DELAY_CLKS - 1);
  localparam logic [CNT_W-1:0] STORE_LAST  = CNT_W'(STORE_CLKS - 1);
  localparam logic [CNT_W-1:0] RECALL_LAST = CNT_W'(RECALL_CLKS - 1);

  stateT state, stateNext;
  logic  trigger;

  assign trigger = extReq || !powerGood;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_WAITPG: if (powerGood) begin
        stateNext     = ST_RECALL;
        strobe.clrCnt = 1'b1;
      end
      ST_RECALL: if (cnt == RECALL_LAST) begin
        stateNext       = ST_IDLE;
        strobe.clrCnt   = 1'b1;
        strobe.clrDirty = 1'b1;
      end
      ST_IDLE: begin
        strobe.takeReq = extReq;
        if (trigger && dirtyNow) begin
          stateNext     = ST_DRAIN;
          strobe.clrCnt = 1'b1;
        end
      end
      ST_DRAIN: if (cnt == DELAY_LAST) begin
        stateNext     = ST_STORE;
        strobe.clrCnt = 1'b1;
      end
      ST_STORE: if (engineDone || cnt == STORE_LAST) begin
        stateNext       = ST_IDLE;
        strobe.clrCnt   = 1'b1;
        strobe.clrDirty = 1'b1;
      end
      default: stateNext = ST_WAITPG;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAITPG;
    else       state <= stateNext;
  end

  assign pullDown    = (state == ST_WAITPG) || (state == ST_RECALL) || (state == ST_STORE);
  assign accInhibit  = (state != ST_IDLE);
  assign storeStart  = (state == ST_STORE) && (cnt == '0);
  assign recallStart = (state == ST_RECALL) && (cnt == '0);

  // R6
  clean_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && extReq && !dirtyNow) |=> !pullDown);

  // R5
  dirty_req_inhibits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && trigger && dirtyNow) |=> accInhibit);

  // R9
  done_releases_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STORE && engineDone) |=> (!pullDown && !accInhibit));

  // R2
  recall_one_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallStart |=> !recallStart);

  // R5
  store_one_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |=> (!storeStart && pullDown));

endmodule

// File: rtl/nv_store_handshake.sv
module nv_store_handshake
  import nvsh_pkg::*;
#(
  parameter int MIN_LOW     = 4,
  parameter int DELAY_CLKS  = 3,
  parameter int STORE_CLKS  = 800000,
  parameter int RECALL_CLKS = 20000
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  input  logic accReq,
  input  logic accWrite,
  input  logic powerGood,
  input  logic engineDone,
  output logic pullDown,
  output logic storeStart,
  output logic recallStart,
  output logic accInhibit
);

  localparam int MAX_A    = (STORE_CLKS > RECALL_CLKS) ? STORE_CLKS : RECALL_CLKS;
  localparam int MAX_CLKS = (MAX_A > DELAY_CLKS) ? MAX_A : DELAY_CLKS;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);

  ctlStrobeT        strobe;
  logic             extReq;
  logic             dirtyNow;
  logic [CNT_W-1:0] cnt;

  nvsh_datapath #(
    .MIN_LOW (MIN_LOW),
    .CNT_W   (CNT_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .lineIn     (lineIn),
    .accReq     (accReq),
    .accWrite   (accWrite),
    .accInhibit (accInhibit),
    .pullDown   (pullDown),
    .strobe     (strobe),
    .extReq     (extReq),
    .dirtyNow   (dirtyNow),
    .cnt        (cnt)
  );

  nvsh_control #(
    .DELAY_CLKS  (DELAY_CLKS),
    .STORE_CLKS  (STORE_CLKS),
    .RECALL_CLKS (RECALL_CLKS),
    .CNT_W       (CNT_W)
  ) i_control (
    .clk         (clk),
    .rstN        (rstN),
    .powerGood   (powerGood),
    .engineDone  (engineDone),
    .extReq      (extReq),
    .dirtyNow    (dirtyNow),
    .cnt         (cnt),
    .strobe      (strobe),
    .pullDown    (pullDown),
    .accInhibit  (accInhibit),
    .storeStart  (storeStart),
    .recallStart (recallStart)
  );

endmodule

// File: tb/test_nv_store_handshake.sv
module test_nv_store_handshake;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_LOW    = 3;
  localparam int DELAY      = 2;
  localparam int STORE      = 20;
  localparam int RECALL     = 10;
  localparam int LAT        = 2 + MIN_LOW + DELAY;
  localparam int NONE       = -1;
  localparam int NVEC       = 9;
  // {write cycle, low pulse length, store expected}
  localparam int VEC [NVEC][3] = '{
    '{0,    6, 1},
    '{NONE, 6, 0},
    '{0,    2, 0},
    '{NONE, 6, 1},
    '{NONE, 3, 0},
    '{0,    3, 1},
    '{4,    6, 1},
    '{6,    6, 0},
    '{NONE, 6, 1}
  };

  logic clk = 1'b0;
  logic rstN, accReq, accWrite, powerGood, engineDone, extLow;
  logic pullDown, storeStart, recallStart, accInhibit;
  logic lineIn;
  int   nChecks = 0;
  int   nFails  = 0;

  assign lineIn = !(extLow || pullDown);

  always #(CLK_PERIOD/2) clk = ~clk;

  nv_store_handshake #(
    .MIN_LOW     (MIN_LOW),
    .DELAY_CLKS  (DELAY),
    .STORE_CLKS  (STORE),
    .RECALL_CLKS (RECALL)
  ) i_nv_store_handshake (
    .clk         (clk),
    .rstN        (rstN),
    .lineIn      (lineIn),
    .accReq      (accReq),
    .accWrite    (accWrite),
    .powerGood   (powerGood),
    .engineDone  (engineDone),
    .pullDown    (pullDown),
    .storeStart  (storeStart),
    .recallStart (recallStart),
    .accInhibit  (accInhibit)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runVec(input int wrAt, input int lenLow, input int doneAt,
                        input int pgAt, input bit wrOnFall,
                        output int first, output int hi, output int inh,
                        output int starts);
    bit prevPd = 1'b0;
    first = -1; hi = 0; inh = 0; starts = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (pullDown) begin
        hi++;
        if (first < 0) first = k;
      end
      inh    += int'(accInhibit);
      starts += int'(storeStart);
      extLow     = (k < lenLow);
      accReq     = (k == wrAt) || (wrOnFall && prevPd && !pullDown);
      accWrite   = accReq;
      engineDone = (k == doneAt);
      if (k == pgAt) powerGood = 1'b0;
      prevPd = pullDown;
    end
    extLow = 1'b0; accReq = 1'b0; accWrite = 1'b0; engineDone = 1'b0;
    powerGood = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int first, hi, inh, starts, rc;
    rstN = 1'b0; accReq = 1'b0; accWrite = 1'b0; powerGood = 1'b0;
    engineDone = 1'b0; extLow = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R1: waiting for power good
    chk("R1 pullDown", int'(pullDown), 1);
    chk("R1 accInhibit", int'(accInhibit), 1);
    chk("R1 recallStart", int'(recallStart), 0);
    chk("R1 storeStart", int'(storeStart), 0);

    // R2: power-up recall
    powerGood = 1'b1;
    rc = 0; hi = 0; inh = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      rc  += int'(recallStart);
      hi  += int'(pullDown);
      inh += int'(accInhibit);
    end
    chk("R2 recallStart pulses", rc, 1);
    chk("R2 pullDown cycles", hi, RECALL);
    chk("R2 accInhibit cycles", inh, RECALL);
    chk("R2 line released", int'(pullDown), 0);

    // Table: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      runVec(VEC[v][0], VEC[v][1], NONE, NONE, 1'b0, first, hi, inh, starts);
      if (VEC[v][2] != 0) begin
        chk($sformatf("R5 vec%0d latency", v), first, LAT);
        chk($sformatf("R9 vec%0d drive length", v), hi, STORE);
        chk($sformatf("R8 vec%0d inhibit length", v), inh, DELAY + STORE);
        chk($sformatf("R5 vec%0d storeStart", v), starts, 1);
      end else begin
        chk($sformatf("R6 vec%0d no drive", v), hi, 0);
        chk($sformatf("R6 vec%0d no inhibit", v), inh, 0);
        chk($sformatf("R4 vec%0d no storeStart", v), starts, 0);
      end
    end

    // R10: write at own release; no ghost request, latch kept
    runVec(0, 6, NONE, NONE, 1'b1, first, hi, inh, starts);
    chk("R10 single store only", hi, STORE);
    chk("R10 storeStart count", starts, 1);
    runVec(NONE, 6, NONE, NONE, 1'b0, first, hi, inh, starts);
    chk("R10 latch kept for next request", starts, 1);

    // R9: early done pulse ends the store, latch cleared
    runVec(0, 6, 10, NONE, 1'b0, first, hi, inh, starts);
    chk("R9 done shortens drive", hi, 10 - LAT + 1);
    runVec(NONE, 6, NONE, NONE, 1'b0, first, hi, inh, starts);
    chk("R9 latch cleared after done", hi, 0);

    // R11: power-good loss while idle and dirty
    runVec(0, 0, NONE, 2, 1'b0, first, hi, inh, starts);
    chk("R11 store latency", first, 3 + DELAY);
    chk("R11 single store while low", hi, STORE);
    chk("R11 storeStart", starts, 1);
    // R11: power-good loss while clean
    runVec(NONE, 0, NONE, 2, 1'b0, first, hi, inh, starts);
    chk("R11 clean no drive", hi, 0);
    // R3: latch holds until a request
    runVec(0, 0, NONE, NONE, 1'b0, first, hi, inh, starts);
    runVec(NONE, 6, NONE, NONE, 1'b0, first, hi, inh, starts);
    chk("R3 latch held", starts, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule